// File: doc/BRIEF.md
# Public-Key Accelerator Host Control and Operand RAM Gate

This block is the host-side front end of a memory-mapped public-key engine. A host talks to it through a single-cycle bus slave port. Every transfer completes in the cycle it is presented, and read data appears in the following cycle. Three 32-bit registers sit at the bottom of the address space: control/status, interrupt flags and interrupt enables. An operand RAM of parameterised depth is mapped at a fixed base above them. The same RAM serves the arithmetic core, which lives outside this block and is reached through a start/done handshake, a soft-reset line and its own RAM port.

While the engine is idle (ready = 1), the host owns the RAM. Once the host sets the start bit, ready drops and the RAM port passes to the core. Host accesses to the RAM in that period are dropped and flagged. The core's done pulse raises ready again, and that rising edge records a completion flag. The core is modelled as running at half the system clock, so the block supplies a clock enable that toggles every cycle. Handshake signals to and from the core are qualified by that enable.

Flags are cleared by writing 1 and then 0 to their bit. While the 1 is held, the flag reads as 0 but still collects new events and still drives the interrupt line. The interrupt output is a registered OR of every flag that is enabled.

Top module: `pka_host_ctrl`

## Requirements
- R1: After reset, control/status (offset 0x00) reads 0x0000_0002, and interrupt flags (0x04) and enables (0x08) read 0. The irq, core_start and core_srst outputs are 0.
- R2: Control bit 0 (start) reads back as last written. Writing it as 1 while ready=1 and soft reset is 0 (and bit 7 of the same write is 0) clears ready at that edge. It also raises core_start, which holds until the end of a cycle in which core_ce=1. A start write while busy has no effect on the run.
- R3: Control bit 1 (ready) is read-only. While busy, ready returns to 1 at the edge where core_done=1, core_ce=1 and core_start is already low.
- R4: Control bit 7 (soft reset) drives core_srst. While it is 1, ready is forced to 1, start writes do nothing, core_start stays low, and the registers and RAM stay accessible with their contents kept.
- R5: Flag bit 0 (completion) is set on the clock edge that follows the cycle in which ready went from 0 to 1.
- R6: A host access to the RAM range while ready=0 sets flag bit 2. The write is dropped and the read returns 0.
- R7: An access at or above base + 4*depth sets flag bit 3, reads 0 and writes nothing. Unused register offsets below the base read 0 and raise no flag.
- R8: Writing 1 to a flag bit clears it and masks its readback while the written 1 is held. Events in that window still set the flag, which becomes visible once 0 is written.
- R9: Enable bits 3, 2 and 0 gate the matching flags. irq is 1 in the cycle after some enabled flag is set and is 0 when no flag is enabled.
- R10: core_ce is 0 in the first cycle after reset and inverts on every clock.
- R11: The RAM port belongs to the host when ready=1 and to the core when ready=0, with one cycle of read latency. Core writes are ignored while ready=1.
- R12: bus_rdata carries the value read by a bus read in the cycle after it, and is 0 in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Transfer valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| irq | output | 1 | Combined interrupt |
| core_ce | output | 1 | Half-rate clock enable for the core |
| core_start | output | 1 | Start request, held until a core_ce cycle |
| core_srst | output | 1 | Core soft reset |
| core_done | input | 1 | Core completion, sampled with core_ce |
| core_mem_we | input | 1 | Core RAM write enable |
| core_mem_addr | input | IDX_W | Core RAM word index |
| core_mem_wdata | input | 32 | Core RAM write data |
| core_mem_rdata | output | 32 | Core RAM read data, one cycle latency |

## Verification
The properties rest on a few assumptions about the inputs. Reset is held for at least two cycles. The core raises core_done only during a run, and holds it long enough to be seen in a cycle where core_ce is high. The stimulus keeps to this: core_done is driven for exactly two cycles and only while ready is low, and the core RAM port is exercised only in the busy window or, deliberately, once while idle to show that the write is ignored. Host transfers are single cycles separated by an idle cycle. Every word of the RAM is written before any read, so no read returns an undefined word.

// File: rtl/pka_hc_pkg.sv
package pka_hc_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned FLG_N  = 3;   // index 0 completion, 1 ram busy, 2 address
  // bit positions in the visible registers
  localparam int unsigned B_START = 0;
  localparam int unsigned B_READY = 1;
  localparam int unsigned B_SRST  = 7;
  localparam int unsigned B_FDONE = 0;
  localparam int unsigned B_FRAM  = 2;
  localparam int unsigned B_FADDR = 3;
  // word offsets of the registers
  localparam int unsigned W_CTRL = 0;
  localparam int unsigned W_FLAG = 1;
  localparam int unsigned W_ENAB = 2;

  typedef enum logic [1:0] {RD_NONE, RD_REG, RD_RAM} rd_src_e;

  function automatic logic [DATA_W-1:0] place_flags(input logic [FLG_N-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[B_FDONE] = v[0];
    r[B_FRAM]  = v[1];
    r[B_FADDR] = v[2];
    return r;
  endfunction
endpackage

// File: rtl/pka_hc_halfrate.sv
module pka_hc_halfrate (
  input  logic clk,
  input  logic rst,
  output logic ce
);
  logic ph_q;
  always_ff @(posedge clk) begin
    if (rst) ph_q <= 1'b0;
    else     ph_q <= ~ph_q;
  end
  assign ce = ph_q;
endmodule

// File: rtl/pka_hc_decode.sv
module pka_hc_decode #(
  parameter int ADDR_W    = 12,
  parameter int RAM_BASE  = 'h400,
  parameter int RAM_WORDS = 64,
  localparam int IDX_W    = $clog2(RAM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_reg,
  output logic              in_ram,
  output logic              beyond,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W:0] BASE_V = (ADDR_W+1)'(RAM_BASE);
  localparam logic [ADDR_W:0] END_V  = (ADDR_W+1)'(RAM_BASE + 4*RAM_WORDS);

  logic [ADDR_W:0]   ext;
  logic [ADDR_W-1:0] off;
  logic              unused_off;

  assign ext    = {1'b0, addr};
  assign in_reg = ext < BASE_V;
  assign in_ram = (ext >= BASE_V) && (ext < END_V);
  assign beyond = ext >= END_V;
  assign off    = addr - BASE_V[ADDR_W-1:0];
  assign idx    = off[IDX_W+1:2];
  assign unused_off = ^{off};
endmodule

// File: rtl/pka_hc_opram.sv
module pka_hc_opram #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [WORDS];
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/pka_hc_regs.sv
module pka_hc_regs
  import pka_hc_pkg::*;
#(
  parameter int WSEL_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              acc,        // register-space transfer this cycle
  input  logic              we,
  input  logic [WSEL_W-1:0] wsel,       // word offset inside register space
  input  logic [DATA_W-1:0] wdata,
  input  logic              ev_ram,
  input  logic              ev_addr,
  input  logic              core_done,
  output logic              ready,
  output logic              core_start,
  output logic              core_srst,
  output logic              irq,
  output logic [FLG_N-1:0]  flags,
  output logic [FLG_N-1:0]  enables,
  output logic [DATA_W-1:0] reg_q
);
  logic start_q, srst_q, rdy_q, rdy_d_q, pend_q, irq_q;
  logic [DATA_W-1:0] rd_q, rd_now;
  logic [FLG_N-1:0]  flg, hold, ena, wbits, evt;
  logic ctrl_w, flag_w, enab_w, launch, unused_wd;

  assign ctrl_w = acc && we && (wsel == WSEL_W'(W_CTRL));
  assign flag_w = acc && we && (wsel == WSEL_W'(W_FLAG));
  assign enab_w = acc && we && (wsel == WSEL_W'(W_ENAB));
  assign wbits  = {wdata[B_FADDR], wdata[B_FRAM], wdata[B_FDONE]};
  assign launch = ctrl_w && wdata[B_START] && !wdata[B_SRST] && rdy_q && !srst_q;
  assign evt    = {ev_addr, ev_ram, rdy_q && !rdy_d_q};
  assign unused_wd = ^{wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      srst_q  <= 1'b0;
      rdy_q   <= 1'b1;
      rdy_d_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      if (ctrl_w) begin
        start_q <= wdata[B_START];
        srst_q  <= wdata[B_SRST];
      end
      rdy_d_q <= rdy_q;
      if (srst_q) begin
        rdy_q  <= 1'b1;
        pend_q <= 1'b0;
      end else if (launch) begin
        rdy_q  <= 1'b0;
        pend_q <= 1'b1;
      end else begin
        if (pend_q && ce) pend_q <= 1'b0;
        if (!rdy_q && !pend_q && core_done && ce) rdy_q <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < FLG_N; g++) begin : g_flag
    logic f_q, h_q, e_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        f_q <= 1'b0;
        h_q <= 1'b0;
        e_q <= 1'b0;
      end else begin
        f_q <= (f_q && !(flag_w && wbits[g])) || evt[g];
        if (flag_w) h_q <= wbits[g];
        if (enab_w) e_q <= wbits[g];
      end
    end
    assign flg[g]  = f_q;
    assign hold[g] = h_q;
    assign ena[g]  = e_q;
  end

  always_comb begin
    rd_now = '0;
    if (acc && !we) begin
      if (wsel == WSEL_W'(W_CTRL)) begin
        rd_now[B_START] = start_q;
        rd_now[B_READY] = rdy_q;
        rd_now[B_SRST]  = srst_q;
      end else if (wsel == WSEL_W'(W_FLAG)) begin
        rd_now = place_flags(flg & ~hold);
      end else if (wsel == WSEL_W'(W_ENAB)) begin
        rd_now = place_flags(ena);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      irq_q <= |(flg & ena);
      rd_q  <= rd_now;
    end
  end

  assign ready      = rdy_q;
  assign core_start = pend_q;
  assign core_srst  = srst_q;
  assign irq        = irq_q;
  assign flags      = flg;
  assign enables    = ena;
  assign reg_q      = rd_q;
endmodule

// File: rtl/pka_host_ctrl.sv
module pka_host_ctrl
  import pka_hc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int RAM_BASE  = 'h400,
  parameter int RAM_WORDS = 64,
  localparam int IDX_W    = $clog2(RAM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              core_ce,
  output logic              core_start,
  output logic              core_srst,
  input  logic              core_done,
  input  logic              core_mem_we,
  input  logic [IDX_W-1:0]  core_mem_addr,
  input  logic [31:0]       core_mem_wdata,
  output logic [31:0]       core_mem_rdata
);
  localparam int WSEL_W = ADDR_W - 2;

  logic             dec_in_reg, dec_in_ram, dec_beyond;
  logic [IDX_W-1:0] dec_idx;
  logic             rdy_w, ce_w, host_ram_busy;
  logic [FLG_N-1:0] flg_w, ien_w;
  logic [31:0]      reg_q_w, ram_q_w, ram_wd;
  logic [IDX_W-1:0] ram_a;
  logic             ram_we;
  rd_src_e          src_q;

  pka_hc_halfrate u_tick (.clk(clk), .rst(rst), .ce(ce_w));

  pka_hc_decode #(.ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .RAM_WORDS(RAM_WORDS)) u_dec (
    .addr(bus_addr), .in_reg(dec_in_reg), .in_ram(dec_in_ram),
    .beyond(dec_beyond), .idx(dec_idx)
  );

  assign host_ram_busy = bus_sel && dec_in_ram && !rdy_w;

  pka_hc_regs #(.WSEL_W(WSEL_W)) u_regs (
    .clk(clk), .rst(rst), .ce(ce_w),
    .acc(bus_sel && dec_in_reg), .we(bus_we), .wsel(bus_addr[ADDR_W-1:2]),
    .wdata(bus_wdata),
    .ev_ram(host_ram_busy), .ev_addr(bus_sel && dec_beyond),
    .core_done(core_done),
    .ready(rdy_w), .core_start(core_start), .core_srst(core_srst), .irq(irq),
    .flags(flg_w), .enables(ien_w), .reg_q(reg_q_w)
  );

  // single RAM port: host while idle, core while busy
  assign ram_we = rdy_w ? (bus_sel && bus_we && dec_in_ram) : core_mem_we;
  assign ram_a  = rdy_w ? dec_idx : core_mem_addr;
  assign ram_wd = rdy_w ? bus_wdata : core_mem_wdata;

  pka_hc_opram #(.DATA_W(32), .WORDS(RAM_WORDS)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_a), .wdata(ram_wd), .q(ram_q_w)
  );

  always_ff @(posedge clk) begin
    if (rst) src_q <= RD_NONE;
    else if (bus_sel && !bus_we && dec_in_ram && rdy_w) src_q <= RD_RAM;
    else if (bus_sel && !bus_we && dec_in_reg) src_q <= RD_REG;
    else src_q <= RD_NONE;
  end

  assign bus_rdata      = (src_q == RD_RAM) ? ram_q_w : reg_q_w;
  assign core_mem_rdata = ram_q_w;
  assign core_ce        = ce_w;
endmodule

// File: rtl/pka_host_ctrl_chk.sv
module pka_host_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       ready,
  input logic       core_start,
  input logic       core_srst,
  input logic       core_ce,
  input logic       irq,
  input logic [2:0] flags,
  input logic [2:0] enables,
  input logic       host_ram_busy
);
  // R1
  a_r1_out_of_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ready && !irq && !core_srst && !core_start));
  // R2
  a_r2_start_only_busy: assert property (@(posedge clk) disable iff (rst)
    core_start |-> !ready);
  // R4
  a_r4_srst_forces_ready: assert property (@(posedge clk) disable iff (rst)
    core_srst |=> ready);
  // R5
  a_r5_done_flag_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |=> flags[0]);
  // R6
  a_r6_busy_access_flag: assert property (@(posedge clk) disable iff (rst)
    host_ram_busy |=> flags[1]);
  // R9
  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (enables == 3'b000 && $past(enables) == 3'b000) |-> !irq);
  // R10
  a_r10_ce_toggles: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (core_ce != $past(core_ce)));
endmodule

bind pka_host_ctrl pka_host_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .ready(rdy_w), .core_start(core_start),
  .core_srst(core_srst), .core_ce(core_ce), .irq(irq),
  .flags(flg_w), .enables(ien_w), .host_ram_busy(host_ram_busy)
);

// File: tb/pka_host_ctrl_test.sv
`timescale 1ns/1ps
module pka_host_ctrl_test;
  localparam int AW = 12;
  localparam int BASE = 'h400;
  localparam int WORDS = 64;
  localparam int ENDA = BASE + 4*WORDS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, core_ce, core_start, core_srst;
  logic core_done = 0, core_mem_we = 0;
  logic [5:0] core_mem_addr = '0;
  logic [31:0] core_mem_wdata = '0;
  logic [31:0] core_mem_rdata;

  always #4 clk = ~clk;

  pka_host_ctrl uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .core_ce(core_ce),
    .core_start(core_start), .core_srst(core_srst), .core_done(core_done),
    .core_mem_we(core_mem_we), .core_mem_addr(core_mem_addr),
    .core_mem_wdata(core_mem_wdata), .core_mem_rdata(core_mem_rdata)
  );

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_go, m_srst, m_rdy, m_rdyd, m_pend, m_ce, m_irq, m_qv;
  bit m_f[3], m_h[3], m_e[3];
  logic [31:0] m_rdata, m_q;
  logic [31:0] mm [WORDS];
  bit known [WORDS];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] fl(input bit b0, input bit b1, input bit b2);
    return (b2 ? 32'h8 : 32'h0) | (b1 ? 32'h4 : 32'h0) | (b0 ? 32'h1 : 32'h0);
  endfunction

  always @(posedge clk) begin
    int a, idx;
    bit inreg, inram, oob, rd, wr, ctrlw, flagw, enw, start, accept;
    bit ev[3], wb[3];
    logic [31:0] rv;
    bit n_irq;
    if (rst) begin
      m_go = 0; m_srst = 0; m_rdy = 1; m_rdyd = 1; m_pend = 0; m_ce = 0; m_irq = 0;
      m_rdata = 0; m_qv = 0;
      for (int i = 0; i < 3; i++) begin m_f[i] = 0; m_h[i] = 0; m_e[i] = 0; end
    end else begin
      a = int'(bus_addr);
      inreg = a < BASE; inram = a >= BASE && a < ENDA; oob = a >= ENDA;
      idx = inram ? (a - BASE) / 4 : 0;
      rd = bus_sel && !bus_we; wr = bus_sel && bus_we;
      wb[0] = bus_wdata[0]; wb[1] = bus_wdata[2]; wb[2] = bus_wdata[3];
      rv = 0;
      if (rd && inreg) begin
        if (a / 4 == 0) rv = (m_srst ? 32'h80 : 0) | (m_rdy ? 32'h2 : 0) | (m_go ? 32'h1 : 0);
        else if (a / 4 == 1) rv = fl(m_f[0] && !m_h[0], m_f[1] && !m_h[1], m_f[2] && !m_h[2]);
        else if (a / 4 == 2) rv = fl(m_e[0], m_e[1], m_e[2]);
      end else if (rd && inram && m_rdy) rv = mm[idx];
      ctrlw = wr && inreg && a / 4 == 0;
      flagw = wr && inreg && a / 4 == 1;
      enw   = wr && inreg && a / 4 == 2;
      start = ctrlw && bus_wdata[0] && !bus_wdata[7] && m_rdy && !m_srst;
      accept = !m_rdy && !m_pend && core_done && m_ce;
      ev[0] = m_rdy && !m_rdyd;
      ev[1] = bus_sel && inram && !m_rdy;
      ev[2] = bus_sel && oob;
      n_irq = (m_f[0] && m_e[0]) || (m_f[1] && m_e[1]) || (m_f[2] && m_e[2]);
      // core RAM read (busy only), read before write
      m_qv = !m_rdy && known[core_mem_addr];
      m_q = mm[core_mem_addr];
      if (m_rdy && wr && inram) begin mm[idx] = bus_wdata; known[idx] = 1; end
      if (!m_rdy && core_mem_we) begin mm[core_mem_addr] = core_mem_wdata; known[core_mem_addr] = 1; end
      for (int i = 0; i < 3; i++) begin
        m_f[i] = (m_f[i] && !(flagw && wb[i])) || ev[i];
        if (flagw) m_h[i] = wb[i];
        if (enw) m_e[i] = wb[i];
      end
      m_rdyd = m_rdy;
      if (m_srst) begin m_rdy = 1; m_pend = 0; end
      else if (start) begin m_rdy = 0; m_pend = 1; end
      else begin
        if (m_pend && m_ce) m_pend = 0;
        if (accept) m_rdy = 1;
      end
      if (ctrlw) begin m_go = bus_wdata[0]; m_srst = bus_wdata[7]; end
      m_irq = n_irq;
      m_ce = !m_ce;
      m_rdata = rv;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(cur_req, bus_rdata, m_rdata);           // R12 and the active requirement
      chk("R9 irq", {31'b0, irq}, {31'b0, m_irq});
      chk("R2 core_start", {31'b0, core_start}, {31'b0, m_pend});
      chk("R4 core_srst", {31'b0, core_srst}, {31'b0, m_srst});
      chk("R10 core_ce", {31'b0, core_ce}, {31'b0, m_ce});
      if (m_qv) chk("R11 core_mem_rdata", core_mem_rdata, m_q);
    end
  end

  task automatic bus(input bit w, input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = w; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(4);
    rst = 0;
    cur_req = "R1";
    bus(0, 'h000, 0); bus(0, 'h004, 0); bus(0, 'h008, 0);
    cur_req = "R12";
    for (int i = 0; i < WORDS; i++) bus(1, BASE + 4*i, 32'h1000_0000 + i * 32'h0101_0003);
    bus(0, BASE, 0); bus(0, BASE + 4*17, 0); bus(0, BASE + 4*63, 0);
    cur_req = "R7 hole";
    bus(0, 'h010, 0); bus(0, 'h3FC, 0); bus(1, 'h00C, 32'hFFFF_FFFF); bus(0, 'h004, 0);
    cur_req = "R9 enable";
    bus(1, 'h008, 32'hFFFF_FFFF); bus(0, 'h008, 0);
    cur_req = "R2 start";
    bus(1, 'h000, 1); bus(0, 'h000, 0);
    bus(1, 'h000, 1); bus(0, 'h000, 0);
    cur_req = "R6 busy access";
    bus(1, BASE + 8, 32'hDEAD_BEEF); bus(0, BASE + 8, 0); bus(0, 'h004, 0);
    cur_req = "R11 core port";
    @(negedge clk); core_mem_we = 1; core_mem_addr = 6'd9; core_mem_wdata = 32'hC0DE_0009;
    @(negedge clk); core_mem_we = 0; core_mem_addr = 6'd9;
    idle(3);
    cur_req = "R3 ready read-only";
    bus(1, 'h000, 0); bus(1, 'h000, 32'h2); bus(0, 'h000, 0);
    @(negedge clk); core_done = 1;
    idle(2); core_done = 0;
    idle(3);
    bus(0, 'h000, 0);
    cur_req = "R11 idle core write";
    @(negedge clk); core_mem_we = 1; core_mem_addr = 6'd3; core_mem_wdata = 32'h0BAD_0BAD;
    @(negedge clk); core_mem_we = 0; core_mem_addr = 6'd0;
    bus(0, BASE + 12, 0); bus(0, BASE + 36, 0);
    cur_req = "R5 completion flag";
    bus(0, 'h004, 0);
    cur_req = "R8 clear sequence";
    bus(1, 'h004, 32'hD); bus(0, 'h004, 0);
    bus(0, 'h900, 0); bus(0, 'h004, 0);
    bus(1, 'h004, 0); bus(0, 'h004, 0);
    bus(1, 'h004, 32'h8); bus(1, 'h004, 0); bus(0, 'h004, 0);
    cur_req = "R7 beyond range";
    bus(1, 'h700, 32'h1234_5678); bus(0, 'h700, 0); bus(0, BASE + 4*63, 0); bus(0, 'h004, 0);
    bus(1, 'h004, 32'h8); bus(1, 'h004, 0);
    cur_req = "R4 soft reset";
    bus(1, 'h000, 1); idle(3);
    bus(1, 'h000, 32'h80); bus(0, 'h000, 0);
    bus(1, 'h000, 32'h81); idle(2); bus(0, 'h000, 0);
    bus(0, BASE + 8, 0); bus(0, 'h008, 0);
    bus(1, 'h000, 0); bus(0, 'h000, 0); bus(0, 'h004, 0);
    cur_req = "R9 disable";
    bus(1, 'h008, 0); idle(3);
    bus(1, 'h004, 32'hD); bus(1, 'h004, 0); bus(0, 'h004, 0);
    idle(2);
    finish_run();
  end
endmodule